// File: doc/BRIEF.md
# Bank Coincidence Sync Pulse Generator

This block raises a synchronization flag for two clock banks, called A and C, that are both derived by integer division from one fast clock. It keeps one phase counter on the fast clock that spans a common period of both banks: the least common multiple of the two divide ratios. Count zero is the fast-clock cycle in which the rising edges of both banks line up. The flag `sync_o` is high most of the time. It drops low for one period of the faster bank just before that shared edge and returns high on the edge itself.

Because the window is derived from the common period and not from either bank alone, the flag also works when the bank frequencies are not integer multiples of each other, such as 3:2 and 4:3. The divided clocks are made elsewhere. This block only needs the two select codes, a stop control and an active-low reset. The stop control forces the flag low while the counter keeps its phase.

Top module: `bank_sync_gen`

## Requirements
- R1: While `rst_n` is low, `sync_o` is low and the phase counter is cleared. The first fast-clock edge after release always starts the counter at phase zero.
- R2: `sel_a` picks the bank A divide ratio: code 0 gives 4, 1 gives 6, 2 gives 8 and 3 gives 12.
- R3: `sel_c` picks the bank C divide ratio: code 0 gives 2, 1 gives 4, 2 gives 6 and 3 gives 8.
- R4: The phase counter steps by one per fast-clock cycle and wraps to zero after LCM(div A, div C) − 1. `sync_o` is high in the phase-zero cycle whenever the ratios differ.
- R5: With stop low, `sync_o` is low exactly in phases LCM − min(div A, div C) through LCM − 1, and high in all other phases. The output only rises at phase zero or when stop is released.
- R6: When both ratios are equal, the low window covers the whole common period, so `sync_o` stays low.
- R7: Non-integer ratios are handled. Bank A ÷4 with bank C ÷6 (3:2) and bank A ÷6 with bank C ÷8 (4:3) give a low window of 4 and 6 fast cycles in periods of 12 and 24.
- R8: On any fast-clock edge where either select code differs from its value at the previous edge, the counter restarts at phase zero.
- R9: From the first edge that samples `stop` high, `sync_o` is low. The counter keeps running. After release, the output follows the phase again from the next edge.
- R10: `sync_o` is registered and reflects the phase in the same cycle in which the counter holds it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock that both banks divide |
| rst_n | input | 1 | Active-low asynchronous master reset |
| sel_a | input | 2 | Bank A divide select code |
| sel_c | input | 2 | Bank C divide select code |
| stop | input | 1 | High forces the sync flag low |
| sync_o | output | 1 | Sync flag, low one faster-bank period before coincidence |

## Verification
Every result is due one fast-clock edge after the inputs that cause it: a select change shows up as phase zero, a high flag (ratios unequal), at the first edge that samples it, and `stop` forces the flag low at that same first edge. The bench drives inputs on the falling edge and samples 1 ns after each rising edge, where a reference model that updates on the same edge has settled. For each of the sixteen select pairs, a separate check walks two common periods from the restart edge and compares every sample against the phase index that the bench computes on its own.

// File: rtl/bsync_pkg.sv
package bsync_pkg;

   function automatic int unsigned gcd_f(input int unsigned a, input int unsigned b);
      int unsigned x;
      int unsigned y;
      int unsigned t;
      x = a;
      y = b;
      while (y != 0) begin
         t = x % y;
         x = y;
         y = t;
      end
      return x;
   endfunction

   function automatic int unsigned lcm_f(input int unsigned a, input int unsigned b);
      return (a / gcd_f(a, b)) * b;
   endfunction

   function automatic int unsigned min_f(input int unsigned a, input int unsigned b);
      return (a < b) ? a : b;
   endfunction

endpackage

// File: rtl/bsync_ratio_lut.sv
module bsync_ratio_lut #(
   parameter int unsigned N_SEL = 4,
   parameter int unsigned CNT_W = 5,
   parameter int unsigned DIV_A [N_SEL] = '{4, 6, 8, 12},
   parameter int unsigned DIV_C [N_SEL] = '{2, 4, 6, 8}
) (
   input  logic [$clog2(N_SEL)-1:0] sel_a,
   input  logic [$clog2(N_SEL)-1:0] sel_c,
   output logic [CNT_W-1:0]         period_last,
   output logic [CNT_W-1:0]         win_start
);
   localparam int unsigned SEL_W = $clog2(N_SEL);
   localparam int unsigned N_ENT = N_SEL * N_SEL;

   logic [CNT_W-1:0] last_tab [N_ENT];
   logic [CNT_W-1:0] wins_tab [N_ENT];

   if (N_SEL != (1 << SEL_W)) begin : g_bad_nsel
      $error("N_SEL must be a power of two");
   end

   for (genvar ia = 0; ia < N_SEL; ia++) begin : g_a
      for (genvar ic = 0; ic < N_SEL; ic++) begin : g_c
         localparam int unsigned LCM = bsync_pkg::lcm_f(DIV_A[ia], DIV_C[ic]);
         localparam int unsigned MIN = bsync_pkg::min_f(DIV_A[ia], DIV_C[ic]);
         if (DIV_A[ia] == 0 || DIV_C[ic] == 0) begin : g_bad_div
            $error("divide ratios must be non-zero");
         end
         if (LCM > (1 << CNT_W)) begin : g_bad_w
            $error("CNT_W too narrow for common period");
         end
         assign last_tab[ia*N_SEL + ic] = CNT_W'(LCM - 1);
         assign wins_tab[ia*N_SEL + ic] = CNT_W'(LCM - MIN);
      end
   end

   logic [2*SEL_W-1:0] idx;
   assign idx         = {sel_a, sel_c};
   assign period_last = last_tab[idx];
   assign win_start   = wins_tab[idx];

endmodule

// File: rtl/bsync_phase_ctr.sv
module bsync_phase_ctr #(
   parameter int unsigned SEL_W = 2,
   parameter int unsigned CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel_a,
   input  logic [SEL_W-1:0] sel_c,
   input  logic [CNT_W-1:0] period_last,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cnt_d
);
   logic [SEL_W-1:0] prev_a;
   logic [SEL_W-1:0] prev_c;
   logic             primed;
   logic             restart;

   assign restart = !primed || (sel_a != prev_a) || (sel_c != prev_c);
   assign cnt_d   = restart ? '0 : ((cnt_q >= period_last) ? '0 : cnt_q + 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         prev_a <= '0;
         prev_c <= '0;
         primed <= 1'b0;
      end else begin
         cnt_q  <= cnt_d;
         prev_a <= sel_a;
         prev_c <= sel_c;
         primed <= 1'b1;
      end
   end

   AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      !restart |-> cnt_q <= period_last); // R4
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && cnt_q < period_last) |=> cnt_q == $past(cnt_q) + 1'b1); // R4
   AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> cnt_q == '0); // R8

endmodule

// File: rtl/bsync_out_gate.sv
module bsync_out_gate #(
   parameter int unsigned CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_d,
   input  logic [CNT_W-1:0] win_start,
   input  logic             stop,
   output logic             sync_o
);
   logic sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= 1'b0;
      else        sync_q <= !stop && (cnt_d < win_start);
   end

   assign sync_o = sync_q;

   AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> !sync_o); // R9

endmodule

// File: rtl/bank_sync_gen.sv
module bank_sync_gen #(
   parameter int unsigned N_SEL = 4,
   parameter int unsigned CNT_W = 5,
   parameter int unsigned DIV_A [N_SEL] = '{4, 6, 8, 12},
   parameter int unsigned DIV_C [N_SEL] = '{2, 4, 6, 8}
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [$clog2(N_SEL)-1:0] sel_a,
   input  logic [$clog2(N_SEL)-1:0] sel_c,
   input  logic                     stop,
   output logic                     sync_o
);
   localparam int unsigned SEL_W = $clog2(N_SEL);

   logic [CNT_W-1:0] period_last;
   logic [CNT_W-1:0] win_start;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;

   bsync_ratio_lut #(
      .N_SEL(N_SEL), .CNT_W(CNT_W), .DIV_A(DIV_A), .DIV_C(DIV_C)
   ) u_lut (
      .sel_a(sel_a), .sel_c(sel_c),
      .period_last(period_last), .win_start(win_start)
   );

   bsync_phase_ctr #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .sel_a(sel_a), .sel_c(sel_c),
      .period_last(period_last), .cnt_q(cnt_q), .cnt_d(cnt_d)
   );

   bsync_out_gate #(.CNT_W(CNT_W)) u_gate (
      .clk(clk), .rst_n(rst_n), .cnt_d(cnt_d), .win_start(win_start),
      .stop(stop), .sync_o(sync_o)
   );

   AST_RISE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync_o) |-> (cnt_q == '0) || $past(stop, 2)); // R5
   AST_EQUAL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (win_start == '0) |=> !sync_o); // R6

endmodule

// File: tb/bank_sync_gen_bench.sv
`timescale 1ns/1ps
module bank_sync_gen_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] sel_a = 2'd0;
   logic [1:0] sel_c = 2'd0;
   logic       stop = 1'b0;
   logic       sync_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;
   bit cmp_en = 0;

   always #2.5 clk = ~clk;

   bank_sync_gen u_bank_sync_gen (
      .clk(clk), .rst_n(rst_n), .sel_a(sel_a), .sel_c(sel_c),
      .stop(stop), .sync_o(sync_o)
   );

   function automatic int dec_a(input logic [1:0] s);
      case (s) 2'd0: return 4; 2'd1: return 6; 2'd2: return 8; default: return 12; endcase
   endfunction
   function automatic int dec_c(input logic [1:0] s);
      case (s) 2'd0: return 2; 2'd1: return 4; 2'd2: return 6; default: return 8; endcase
   endfunction
   function automatic int lcm(input int a, input int b);
      int m;
      m = a;
      while ((m % b) != 0) m = m + a;
      return m;
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: sync_o=%b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // Behavioural reference, updated on each rising edge
   int   m_ph = 0;
   bit   m_prim = 0;
   logic [1:0] m_pa = 0, m_pc = 0;
   logic m_exp = 0;
   always @(posedge clk) begin
      int l, mn;
      if (!rst_n) begin
         m_ph = 0; m_prim = 0; m_exp = 0;
      end else begin
         l  = lcm(dec_a(sel_a), dec_c(sel_c));
         mn = (dec_a(sel_a) < dec_c(sel_c)) ? dec_a(sel_a) : dec_c(sel_c);
         if (!m_prim || sel_a != m_pa || sel_c != m_pc) m_ph = 0;
         else m_ph = (m_ph + 1) % l;
         m_prim = 1; m_pa = sel_a; m_pc = sel_c;
         m_exp = !stop && (m_ph < l - mn);
      end
   end

   always @(posedge clk) begin
      #1;
      if (cmp_en) check("R10 model", sync_o, m_exp);
   end

   task automatic run_pair(input logic [1:0] a, input logic [1:0] c);
      int da, dc, l, mn;
      da = dec_a(a); dc = dec_c(c);
      l  = lcm(da, dc);
      mn = (da < dc) ? da : dc;
      sel_a = a; sel_c = c;
      for (int i = 0; i < 2*l; i++) begin
         @(posedge clk); #1;
         if (da == dc) check("R6 equal ratio low", sync_o, 1'b0);
         else if ((a == 2'd0 && c == 2'd2) || (a == 2'd1 && c == 2'd3))
            check("R7 non-integer window", sync_o, ((i % l) < l - mn));
         else if (i == 0) check("R4 high at phase zero", sync_o, 1'b1);
         else check("R5 R2 R3 window position", sync_o, ((i % l) < l - mn));
      end
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset low", sync_o, 1'b0);
      cmp_en = 1;
      rst_n = 1'b1;
      for (int a = 0; a < 4; a++)
         for (int c = 0; c < 4; c++)
            run_pair(2'(a), 2'(c));
      run_pair(2'd1, 2'd0);
      // stop holds low, counter keeps running
      stop = 1'b1;
      for (int i = 0; i < 7; i++) begin
         @(posedge clk); #1;
         check("R9 stop low", sync_o, 1'b0);
      end
      @(negedge clk);
      stop = 1'b0;
      repeat (8) @(negedge clk);
      // mid-period ratio change restarts
      repeat (3) @(negedge clk);
      sel_a = 2'd2; sel_c = 2'd1;
      @(posedge clk); #1;
      check("R8 restart high", sync_o, 1'b1);
      @(negedge clk);
      run_pair(2'd3, 2'd0);
      // reset mid-run
      rst_n = 1'b0;
      @(posedge clk); #1;
      check("R1 reset mid-run", sync_o, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      check("R1 restart after reset", sync_o, 1'b1);
      @(negedge clk);
      repeat (10) @(negedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule